// File: doc/BRIEF.md
# Recirculating Cube Network with Per-Node Function Select

This block moves one data word per processing element (PE) between the N = 2^n PEs of a lock-step array. Its one switching stage is based on the hypercube neighbourhood: function Cube_i carries a word from PE p to the PE whose address differs from p only in bit i. The stage is used again on each pass. The first pass reads each PE's input register, and every later pass reads the output registers that the pass before it wrote. A launch strobe starts a programmed number of passes. A done flag marks the end of the run.

Each PE has its own function-select register, so in one pass the PEs may apply different cube functions. A PE may also select several functions at once and broadcast to all of the matching neighbours. A PE flagged inactive still receives but drives nothing. A shared partition mask removes chosen cube functions from every PE, which splits the array into independent groups. When several senders land on one PE, the receiving line ORs them together and a per-PE collision flag is raised.

Top module: `cube_recirc_net`

## Requirements
- R1: After reset, every output word, the done flag and every collision flag are zero.
- R2: Bit i of a PE's function-select register (bit 0 = Cube_0) makes that PE, when active, send its word during a pass to the PE whose address is its own with bit i inverted.
- R3: PEs holding different function-select values apply them in the same pass, each PE following only its own register.
- R4: A PE with several select bits set delivers its word to every addressed neighbour in the same pass.
- R5: An inactive PE drives nothing. A PE that no active sender addresses in a pass loads zero into its output word.
- R6: A PE reached by two or more senders in one pass receives the bitwise OR of their words and raises its collision flag. Collision flags accumulate over a run and are cleared when the next run launches.
- R7: The pass performed on the launch edge takes its operands from the input registers. Every further pass in the run takes them from the output registers, so M passes compose M network steps.
- R8: A launch with pass count M (4 bits, 0 treated as 1) performs exactly M passes, the first on the launch edge. Done rises on the edge of the last pass. Done and the output words then hold until the next launch.
- R9: Setting bit i of the partition mask suppresses Cube_i in every PE, whatever its select register holds.
- R10: A load strobe bit writes only that PE's input register. Loading alters no output word until a pass runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| din | input | N*DATA_W | Per-PE input words, PE p at bits p*DATA_W upward |
| load | input | N | Per-PE input register write strobe |
| sel_wdata | input | N*ADDR_W | Per-PE function-select write values |
| sel_we | input | N | Per-PE function-select write strobe |
| part_wdata | input | ADDR_W | Partition mask write value |
| part_we | input | 1 | Partition mask write strobe |
| active | input | N | Per-PE send enable |
| passes_m | input | PASS_W | Number of passes for the next run |
| go | input | 1 | Launch strobe |
| dout | output | N*DATA_W | Per-PE output registers |
| done | output | 1 | Run complete |
| collision | output | N | Per-PE multiple-sender flag |

## Verification
A uniform Cube_0 pattern shows that one address bit is flipped for every PE. A mixed pattern, where each PE picks a different function, shows that the selects are read per PE and not shared. A lone three-way broadcast and a two-senders-to-one pattern separate fan-out from fan-in, and the fan-in case also shows the OR and the collision flag. Runs of two and three passes, compared against a step-by-step model, show whether the later passes really recirculate the outputs. A full-select run under a partition mask and a run with every PE inactive show that masked functions and idle senders contribute nothing.

// File: rtl/cube_net_pkg.sv
package cube_net_pkg;
  typedef enum logic [0:0] {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_e;
endpackage

// File: rtl/cube_sel_regs.sv
// Per-PE function-select registers plus the shared partition mask.
module cube_sel_regs #(
  parameter int N      = 8,
  parameter int ADDR_W = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N*ADDR_W-1:0] sel_wdata,
  input  logic [N-1:0]        sel_we,
  input  logic [ADDR_W-1:0]   part_wdata,
  input  logic                part_we,
  output logic [N*ADDR_W-1:0] eff_sel
);
  logic [ADDR_W-1:0] sel_q [N];
  logic [ADDR_W-1:0] sel_d [N];
  logic [ADDR_W-1:0] mask_q, mask_d;

  always_comb begin
    mask_d = part_we ? part_wdata : mask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= mask_d;
  end

  for (genvar gp = 0; gp < N; gp++) begin : g_sel
    always_comb begin
      sel_d[gp] = sel_we[gp] ? sel_wdata[gp*ADDR_W +: ADDR_W] : sel_q[gp];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sel_q[gp] <= '0;
      else        sel_q[gp] <= sel_d[gp];
    end

    assign eff_sel[gp*ADDR_W +: ADDR_W] = sel_q[gp] & ~mask_q;
  end
endmodule

// File: rtl/cube_xbar.sv
// One cube stage: every receiver ORs the words of the neighbours that target it.
module cube_xbar #(
  parameter int N      = 8,
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8
) (
  input  logic [N*DATA_W-1:0] src,
  input  logic [N-1:0]        active,
  input  logic [N*ADDR_W-1:0] eff_sel,
  output logic [N*DATA_W-1:0] recv,
  output logic [N-1:0]        multi
);
  for (genvar gp = 0; gp < N; gp++) begin : g_rx
    logic [DATA_W-1:0] acc;
    logic              seen;
    logic              dup;

    always_comb begin
      acc  = '0;
      seen = 1'b0;
      dup  = 1'b0;
      for (int i = 0; i < ADDR_W; i++) begin
        int nb;
        nb = gp ^ (1 << i);
        if (active[nb] && eff_sel[nb*ADDR_W + i]) begin
          acc  = acc | src[nb*DATA_W +: DATA_W];
          dup  = dup | seen;
          seen = 1'b1;
        end
      end
    end

    assign recv[gp*DATA_W +: DATA_W] = acc;
    assign multi[gp] = dup;
  end
endmodule

// File: rtl/cube_pass_seq.sv
// Pass counter: the launch edge is pass 1, and done rises on pass M.
module cube_pass_seq
  import cube_net_pkg::*;
#(
  parameter int PASS_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [PASS_W-1:0] passes_m,
  output logic              pass_en,
  output logic              first_pass,
  output logic              done
);
  localparam logic [PASS_W-1:0] ONE = PASS_W'(1);

  seq_state_e        st_q, st_d;
  logic [PASS_W-1:0] cnt_q, cnt_d;
  logic [PASS_W-1:0] tgt_q, tgt_d;
  logic              done_q, done_d;
  logic [PASS_W-1:0] tgt_in;

  assign tgt_in     = (passes_m == '0) ? ONE : passes_m;
  assign pass_en    = go || (st_q == SEQ_RUN);
  assign first_pass = go;
  assign done       = done_q;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    tgt_d  = tgt_q;
    done_d = done_q;
    if (go) begin
      tgt_d  = tgt_in;
      cnt_d  = ONE;
      done_d = (tgt_in == ONE);
      st_d   = (tgt_in == ONE) ? SEQ_IDLE : SEQ_RUN;
    end else if (st_q == SEQ_RUN) begin
      cnt_d = cnt_q + ONE;
      if (cnt_q + ONE == tgt_q) begin
        st_d   = SEQ_IDLE;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SEQ_IDLE;
      cnt_q  <= '0;
      tgt_q  <= ONE;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      tgt_q  <= tgt_d;
      done_q <= done_d;
    end
  end
endmodule

// File: rtl/cube_recirc_net.sv
module cube_recirc_net #(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8,
  parameter int PASS_W = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [(1<<ADDR_W)*DATA_W-1:0] din,
  input  logic [(1<<ADDR_W)-1:0]        load,
  input  logic [(1<<ADDR_W)*ADDR_W-1:0] sel_wdata,
  input  logic [(1<<ADDR_W)-1:0]        sel_we,
  input  logic [ADDR_W-1:0]             part_wdata,
  input  logic                          part_we,
  input  logic [(1<<ADDR_W)-1:0]        active,
  input  logic [PASS_W-1:0]             passes_m,
  input  logic                          go,
  output logic [(1<<ADDR_W)*DATA_W-1:0] dout,
  output logic                          done,
  output logic [(1<<ADDR_W)-1:0]        collision
);
  localparam int N = 1 << ADDR_W;

  logic [N*ADDR_W-1:0] eff_sel;
  logic [N*DATA_W-1:0] in_q, in_d;
  logic [N*DATA_W-1:0] out_q, out_d;
  logic [N*DATA_W-1:0] src, recv;
  logic [N-1:0]        multi;
  logic [N-1:0]        col_q, col_d;
  logic                pass_en, first_pass;

  cube_sel_regs #(.N(N), .ADDR_W(ADDR_W)) u_sel (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel_wdata  (sel_wdata),
    .sel_we     (sel_we),
    .part_wdata (part_wdata),
    .part_we    (part_we),
    .eff_sel    (eff_sel)
  );

  cube_pass_seq #(.PASS_W(PASS_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .go         (go),
    .passes_m   (passes_m),
    .pass_en    (pass_en),
    .first_pass (first_pass),
    .done       (done)
  );

  assign src = first_pass ? in_q : out_q;

  cube_xbar #(.N(N), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_xbar (
    .src     (src),
    .active  (active),
    .eff_sel (eff_sel),
    .recv    (recv),
    .multi   (multi)
  );

  for (genvar gp = 0; gp < N; gp++) begin : g_in
    always_comb begin
      in_d[gp*DATA_W +: DATA_W] = load[gp] ? din[gp*DATA_W +: DATA_W]
                                           : in_q[gp*DATA_W +: DATA_W];
    end
  end

  always_comb begin
    out_d = pass_en ? recv : out_q;
    col_d = col_q;
    if (first_pass)   col_d = multi;
    else if (pass_en) col_d = col_q | multi;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_q  <= '0;
      out_q <= '0;
      col_q <= '0;
    end else begin
      in_q  <= in_d;
      out_q <= out_d;
      col_q <= col_d;
    end
  end

  assign dout      = out_q;
  assign collision = col_q;
endmodule

// File: rtl/cube_net_chk.sv
module cube_net_chk #(
  parameter int N      = 8,
  parameter int DATA_W = 8,
  parameter int PASS_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              go,
  input logic [PASS_W-1:0] passes_m,
  input logic [N-1:0]      active,
  input logic [N*DATA_W-1:0] dout,
  input logic              done,
  input logic [N-1:0]      collision
);
  p_done_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !go) |=> done);

  p_dout_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !go) |=> $stable(dout));

  p_long_run_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (go && passes_m > PASS_W'(1)) |=> !done);

  p_short_run_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (go && passes_m <= PASS_W'(1)) |=> done);

  p_silent_senders_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (go && active == '0) |=> (dout == '0 && collision == '0));
endmodule

bind cube_recirc_net cube_net_chk #(.N(1 << ADDR_W), .DATA_W(DATA_W), .PASS_W(PASS_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .go        (go),
  .passes_m  (passes_m),
  .active    (active),
  .dout      (dout),
  .done      (done),
  .collision (collision)
);

// File: tb/cube_recirc_net_bench.sv
module cube_recirc_net_bench;
  localparam int A = 3;
  localparam int N = 8;
  localparam int D = 8;
  localparam int P = 4;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [N*D-1:0] din = '0;
  logic [N-1:0]   load = '0;
  logic [N*A-1:0] sel_wdata = '0;
  logic [N-1:0]   sel_we = '0;
  logic [A-1:0]   part_wdata = '0;
  logic           part_we = 1'b0;
  logic [N-1:0]   active = '0;
  logic [P-1:0]   passes_m = '0;
  logic           go = 1'b0;
  logic [N*D-1:0] dout;
  logic           done;
  logic [N-1:0]   collision;

  always #10 clk = ~clk;

  cube_recirc_net #(.ADDR_W(A), .DATA_W(D), .PASS_W(P)) u_cube_recirc_net (
    .clk(clk), .rst_n(rst_n), .din(din), .load(load), .sel_wdata(sel_wdata),
    .sel_we(sel_we), .part_wdata(part_wdata), .part_we(part_we), .active(active),
    .passes_m(passes_m), .go(go), .dout(dout), .done(done), .collision(collision)
  );

  int total = 0;
  int failed = 0;
  logic [D-1:0] in_a  [N];
  logic [A-1:0] sel_a [N];
  logic [D-1:0] cur   [N];
  logic [N-1:0] exp_col;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [N*D-1:0] pack_cur();
    logic [N*D-1:0] v;
    for (int p = 0; p < N; p++) v[p*D +: D] = cur[p];
    return v;
  endfunction

  task automatic model(input int m, input logic [N-1:0] act, input logic [A-1:0] pm);
    logic [D-1:0] nxt [N];
    int steps;
    steps = (m < 1) ? 1 : m;
    exp_col = '0;
    for (int s = 0; s < steps; s++) begin
      for (int p = 0; p < N; p++) begin
        int hits;
        hits = 0;
        nxt[p] = '0;
        for (int i = 0; i < A; i++) begin
          int q;
          q = p ^ (1 << i);
          if (act[q] && sel_a[q][i] && !pm[i]) begin
            nxt[p] |= (s == 0) ? in_a[q] : cur[q];
            hits++;
          end
        end
        if (hits > 1) exp_col[p] = 1'b1;
      end
      for (int p = 0; p < N; p++) cur[p] = nxt[p];
    end
  endtask

  task automatic load_words(input logic [N-1:0] which);
    @(negedge clk);
    for (int p = 0; p < N; p++) din[p*D +: D] = in_a[p];
    load = which;
    @(negedge clk);
    load = '0;
  endtask

  task automatic write_sel(input logic [A-1:0] pm);
    @(negedge clk);
    for (int p = 0; p < N; p++) sel_wdata[p*A +: A] = sel_a[p];
    sel_we = '1;
    part_wdata = pm;
    part_we = 1'b1;
    @(negedge clk);
    sel_we = '0;
    part_we = 1'b0;
  endtask

  task automatic run(input int m, output int cyc);
    passes_m = P'(m);
    go = 1'b1;
    @(posedge clk);
    @(negedge clk);
    go = 1'b0;
    cyc = 1;
    while (!done && cyc < 40) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic run_and_check(input string req, input int m, input logic [N-1:0] act, input logic [A-1:0] pm);
    int cyc;
    active = act;
    run(m, cyc);
    model(m, act, pm);
    check(dout == pack_cur(), req, dout, pack_cur());
    check(collision == exp_col, {req, " collision"}, collision, exp_col);
    check(cyc == ((m < 1) ? 1 : m), {req, " R8 pass count"}, cyc, (m < 1) ? 1 : m);
  endtask

  task automatic t_reset();
    check(dout == '0, "R1 dout", dout, 0);
    check(done == 1'b0, "R1 done", done, 0);
    check(collision == '0, "R1 collision", collision, 0);
  endtask

  task automatic t_uniform_cube0();
    for (int p = 0; p < N; p++) begin in_a[p] = D'(p * 17 + 1); sel_a[p] = 3'b001; end
    load_words('1);
    write_sel('0);
    run_and_check("R2 uniform Cube_0", 1, '1, '0);
    check(dout[3*D +: D] == in_a[2], "R2 PE3 from PE2", dout[3*D +: D], in_a[2]);
  endtask

  task automatic t_mixed();
    for (int p = 0; p < N; p++) sel_a[p] = A'(1 << (p % 3));
    write_sel('0);
    run_and_check("R3 mixed selects", 1, '1, '0);
  endtask

  task automatic t_broadcast();
    for (int p = 0; p < N; p++) sel_a[p] = '0;
    sel_a[0] = 3'b111;
    write_sel('0);
    run_and_check("R4 broadcast", 1, 8'h01, '0);
    check(dout[4*D +: D] == in_a[0] && dout[7*D +: D] == '0, "R4 PE4 got PE0, PE7 empty",
          {dout[4*D +: D], dout[7*D +: D]}, {in_a[0], 8'h00});
  endtask

  task automatic t_inactive();
    for (int p = 0; p < N; p++) sel_a[p] = 3'b111;
    write_sel('0);
    run_and_check("R5 all inactive", 1, '0, '0);
    run_and_check("R5 only PE5 active", 1, 8'h20, '0);
  endtask

  task automatic t_collision();
    for (int p = 0; p < N; p++) sel_a[p] = '0;
    sel_a[1] = 3'b010;
    sel_a[2] = 3'b001;
    write_sel('0);
    run_and_check("R6 two senders", 1, 8'h06, '0);
    check(collision == 8'h08, "R6 flag on PE3", collision, 8'h08);
    check(dout[3*D +: D] == (in_a[1] | in_a[2]), "R6 OR value", dout[3*D +: D], in_a[1] | in_a[2]);
    for (int p = 0; p < N; p++) sel_a[p] = 3'b001;
    write_sel('0);
    run_and_check("R6 flags cleared on launch", 1, '1, '0);
  endtask

  task automatic t_recirc();
    for (int p = 0; p < N; p++) sel_a[p] = 3'b001;
    write_sel('0);
    run_and_check("R7 two Cube_0 passes", 2, '1, '0);
    for (int p = 0; p < N; p++)
      check(dout[p*D +: D] == in_a[p], "R7 round trip", dout[p*D +: D], in_a[p]);
    for (int p = 0; p < N; p++) sel_a[p] = A'(1 << ((p + 1) % 3));
    write_sel('0);
    run_and_check("R7 three mixed passes", 3, 8'hDB, '0);
  endtask

  task automatic t_count();
    logic [N*D-1:0] snap;
    for (int p = 0; p < N; p++) sel_a[p] = 3'b011;
    write_sel('0);
    run_and_check("R8 M=0", 0, '1, '0);
    run_and_check("R8 M=15", 15, '1, '0);
    snap = dout;
    repeat (3) @(negedge clk);
    check(done == 1'b1 && dout == snap, "R8 hold after done", dout, snap);
  endtask

  task automatic t_partition();
    for (int p = 0; p < N; p++) sel_a[p] = 3'b111;
    write_sel(3'b100);
    run_and_check("R9 mask Cube_2", 1, '1, 3'b100);
    write_sel(3'b011);
    run_and_check("R9 mask Cube_0 and Cube_1", 1, '1, 3'b011);
    write_sel('0);
  endtask

  task automatic t_load();
    logic [N*D-1:0] snap;
    for (int p = 0; p < N; p++) sel_a[p] = 3'b001;
    write_sel('0);
    run_and_check("R10 baseline", 1, '1, '0);
    snap = dout;
    in_a[3] = 8'hA5;
    for (int p = 0; p < N; p++) din[p*D +: D] = 8'hFF;
    din[3*D +: D] = 8'hA5;
    @(negedge clk);
    load = 8'h08;
    @(negedge clk);
    load = '0;
    @(negedge clk);
    check(dout == snap, "R10 no change before pass", dout, snap);
    run_and_check("R10 only PE3 reloaded", 1, '1, '0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_uniform_cube0();
    t_mixed();
    t_broadcast();
    t_inactive();
    t_collision();
    t_recirc();
    t_count();
    t_partition();
    t_load();
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    failed++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule